// File: doc/BRIEF.md
# Two-Priority DMA Request Dispatcher

This block feeds one DMA engine from two request queues. Control messages between processors, such as buffer-release notices, go into the urgent queue. Packet data goes into the bulk queue. Each request holds a direction, a local address, a remote address, a byte length and a tag.

Setting up a DMA transfer costs more than it saves on a short block. For that reason, any request shorter than a threshold is steered to a programmed-I/O port instead of the engine. The threshold is held in a register that resets to 168 bytes.

The engine takes one transfer at a time and signals the end of each transfer with a done pulse carrying its tag. The requester does not wait for that pulse: once a transfer is accepted, the queue moves on, and short transfers keep flowing to programmed I/O while the engine works. Every finished transfer, on either path, produces one completion pulse that carries the tag.

All request and dispatch interfaces use valid/ready:
- A transfer happens on a clock edge where valid and ready are both high.
- Once the dispatcher raises a valid on the DMA or programmed-I/O port, it holds valid and all fields unchanged until ready is seen.
- The queue a pending offer came from, and the path it was routed to, are fixed at the moment of the first offer.
- A queue input drops ready while the queue is full; a valid presented then is not taken.

Top module: `dma_dispatch`

## Requirements
- R1: After reset both queues are empty, `hi_ready` and `lo_ready` are high, `dma_valid`, `pio_valid` and `cmp_valid` are low, and the size threshold is 168.
- R2: Each queue holds up to DEPTH requests in arrival order. Its ready is low while DEPTH entries are held, and a request presented while ready is low is dropped.
- R3: When no offer is pending, the urgent queue's head is always chosen if that queue is non-empty. A bulk request is offered only when the urgent queue is empty, and a bulk request routed to DMA additionally waits for the engine to be idle.
- R4: A request whose length is strictly below the threshold is offered on the programmed-I/O port; otherwise it is offered on the DMA port. Direction (0 = push, local to remote; 1 = pull, remote to local), both addresses, length and tag are passed through unchanged.
- R5: The engine is used one transfer at a time. `dma_valid` stays low from the edge a DMA transfer is accepted until the edge where `dma_done` is seen.
- R6: Once a DMA transfer is accepted it leaves its queue. Requests routed to programmed I/O are dispatched while the engine is still busy.
- R7: A write through `thr_we`/`thr_wdata` replaces the threshold and governs the routing of every later offer.
- R8: `cmp_valid` pulses for one cycle, with the tag and `cmp_pio` (1 = programmed I/O), in the cycle after a `dma_done` or a programmed-I/O acceptance. When both happen in the same cycle, the DMA completion comes first and the programmed-I/O completion follows one cycle later.
- R9: While `dma_valid` or `pio_valid` is high and its ready is low, that valid and its tag stay unchanged in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| hi_valid | input | 1 | Urgent request valid |
| hi_ready | output | 1 | Urgent queue can accept |
| hi_dir | input | 1 | Urgent direction, 0 push / 1 pull |
| hi_laddr | input | ADDR_W | Urgent local address |
| hi_raddr | input | ADDR_W | Urgent remote address |
| hi_len | input | LEN_W | Urgent length in bytes |
| hi_tag | input | TAG_W | Urgent request tag |
| lo_valid | input | 1 | Bulk request valid |
| lo_ready | output | 1 | Bulk queue can accept |
| lo_dir | input | 1 | Bulk direction |
| lo_laddr | input | ADDR_W | Bulk local address |
| lo_raddr | input | ADDR_W | Bulk remote address |
| lo_len | input | LEN_W | Bulk length in bytes |
| lo_tag | input | TAG_W | Bulk request tag |
| thr_we | input | 1 | Threshold write strobe |
| thr_wdata | input | LEN_W | New threshold value |
| dma_valid | output | 1 | Transfer offered to the DMA engine |
| dma_ready | input | 1 | Engine accepts the transfer |
| dma_dir | output | 1 | Direction to engine |
| dma_laddr | output | ADDR_W | Local address to engine |
| dma_raddr | output | ADDR_W | Remote address to engine |
| dma_len | output | LEN_W | Length to engine |
| dma_tag | output | TAG_W | Tag to engine |
| dma_done | input | 1 | Engine finished a transfer |
| dma_done_tag | input | TAG_W | Tag of the finished transfer |
| pio_valid | output | 1 | Transfer offered to programmed I/O |
| pio_ready | input | 1 | Programmed-I/O path takes and completes it |
| pio_dir | output | 1 | Direction to programmed I/O |
| pio_laddr | output | ADDR_W | Local address to programmed I/O |
| pio_raddr | output | ADDR_W | Remote address to programmed I/O |
| pio_len | output | LEN_W | Length to programmed I/O |
| pio_tag | output | TAG_W | Tag to programmed I/O |
| cmp_valid | output | 1 | Completion pulse |
| cmp_tag | output | TAG_W | Tag of the completed transfer |
| cmp_pio | output | 1 | Completion came from programmed I/O |

## Verification
The bench builds the block with its defaults: DEPTH = 4, a 16-bit length, 32-bit addresses, 4-bit tags and a reset threshold of 168.

With a depth of four, the full-queue state is reached after a handful of pushes, so a refused fifth push and the in-order drain of the queue can both be observed. The 16-bit length reaches both sides of the crossover: 167 and 168, plus 0 and 65535. The threshold register is also rewritten to 64 to move the crossover.

Because the completion ports are driven directly by the bench, a `dma_done` can be made to coincide with a programmed-I/O acceptance, which exercises the ordering of the two completions.

// File: rtl/dmad_pkg.sv
package dmad_pkg;
  localparam int NUM_CLASS = 2;
  localparam int CLS_HI    = 0;
  localparam int CLS_LO    = 1;

  typedef enum logic {
    XFER_PUSH = 1'b0,
    XFER_PULL = 1'b1
  } xfer_dir_e;
endpackage

// File: rtl/dmad_fifo.sv
module dmad_fifo #(
  parameter int W     = 8,
  parameter int DEPTH = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         in_valid,
  output logic         in_ready,
  input  logic [W-1:0] in_data,
  output logic         out_valid,
  input  logic         out_pop,
  output logic [W-1:0] out_data
);
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);

  logic [W-1:0]  mem [DEPTH];
  logic [PW-1:0] wp, rp;
  logic [CW-1:0] cnt;
  logic          push, pop;

  assign in_ready  = (cnt != CW'(DEPTH));
  assign out_valid = (cnt != '0);
  assign out_data  = mem[rp];
  assign push      = in_valid & in_ready;
  assign pop       = out_pop & out_valid;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wp  <= '0;
      rp  <= '0;
      cnt <= '0;
    end else begin
      if (push) begin
        mem[wp] <= in_data;
        wp      <= (wp == PW'(DEPTH - 1)) ? '0 : wp + 1'b1;
      end
      if (pop) rp <= (rp == PW'(DEPTH - 1)) ? '0 : rp + 1'b1;
      if (push && !pop)      cnt <= cnt + 1'b1;
      else if (!push && pop) cnt <= cnt - 1'b1;
    end
  end

  // Queue occupancy follows accepted pushes (R2)
  assert_count_track_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready && !out_pop) |=> (cnt == $past(cnt) + 1'b1));
endmodule

// File: rtl/dmad_select.sv
module dmad_select #(
  parameter int RW         = 32,
  parameter int LEN_W      = 16,
  parameter int TAG_W      = 4,
  parameter int THRESH_RST = 168
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             hi_avail,
  input  logic [RW-1:0]    hi_head,
  input  logic             lo_avail,
  input  logic [RW-1:0]    lo_head,
  input  logic             thr_we,
  input  logic [LEN_W-1:0] thr_wdata,
  input  logic             dma_ready,
  input  logic             dma_done,
  input  logic             pio_ready,
  input  logic             pio_block,
  output logic             hi_pop,
  output logic             lo_pop,
  output logic             dma_valid,
  output logic             pio_valid,
  output logic             pio_fire,
  output logic [RW-1:0]    req_data
);
  logic             lock_v, lock_lo, lock_pio;
  logic             busy;
  logic [LEN_W-1:0] thr;
  logic             use_lo, to_pio, offer, dma_fire, any_fire;
  logic [LEN_W-1:0] head_len;

  assign use_lo   = lock_v ? lock_lo : !hi_avail;
  assign req_data = use_lo ? lo_head : hi_head;
  assign head_len = req_data[TAG_W +: LEN_W];
  assign to_pio   = lock_v ? lock_pio : (head_len < thr);
  assign offer    = lock_v | hi_avail | lo_avail;

  assign dma_valid = offer & ~to_pio & ~busy;
  assign pio_valid = offer & to_pio & ~pio_block;
  assign dma_fire  = dma_valid & dma_ready;
  assign pio_fire  = pio_valid & pio_ready;
  assign any_fire  = dma_fire | pio_fire;
  assign hi_pop    = any_fire & ~use_lo;
  assign lo_pop    = any_fire & use_lo;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      lock_v   <= 1'b0;
      lock_lo  <= 1'b0;
      lock_pio <= 1'b0;
      busy     <= 1'b0;
      thr      <= LEN_W'(THRESH_RST);
    end else begin
      lock_v   <= (dma_valid & ~dma_ready) | (pio_valid & ~pio_ready);
      lock_lo  <= use_lo;
      lock_pio <= to_pio;
      if (dma_fire)      busy <= 1'b1;
      else if (dma_done) busy <= 1'b0;
      if (thr_we) thr <= thr_wdata;
    end
  end

  // Engine takes one transfer at a time (R5)
  assert_single_xfer_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (dma_valid && dma_ready) |=> !dma_valid);

  // Offers are held until taken (R9)
  assert_dma_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (dma_valid && !dma_ready) |=> (dma_valid && $stable(req_data)));
  assert_pio_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (pio_valid && !pio_ready) |=> (pio_valid && $stable(req_data)));
endmodule

// File: rtl/dmad_complete.sv
module dmad_complete #(
  parameter int TAG_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             dma_done,
  input  logic [TAG_W-1:0] dma_done_tag,
  input  logic             pio_fire,
  input  logic [TAG_W-1:0] pio_tag,
  output logic             hold_full,
  output logic             cmp_valid,
  output logic [TAG_W-1:0] cmp_tag,
  output logic             cmp_pio
);
  logic [TAG_W-1:0] hold_tag;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hold_full <= 1'b0;
      hold_tag  <= '0;
      cmp_valid <= 1'b0;
      cmp_tag   <= '0;
      cmp_pio   <= 1'b0;
    end else begin
      cmp_valid <= 1'b0;
      if (dma_done) begin
        cmp_valid <= 1'b1;
        cmp_tag   <= dma_done_tag;
        cmp_pio   <= 1'b0;
        if (pio_fire) begin
          hold_full <= 1'b1;
          hold_tag  <= pio_tag;
        end
      end else if (pio_fire) begin
        cmp_valid <= 1'b1;
        cmp_tag   <= pio_tag;
        cmp_pio   <= 1'b1;
      end else if (hold_full) begin
        cmp_valid <= 1'b1;
        cmp_tag   <= hold_tag;
        cmp_pio   <= 1'b1;
        hold_full <= 1'b0;
      end
    end
  end

  // Every completion has a cause in the previous cycle (R8)
  assert_cmp_cause_R8: assert property (@(posedge clk) disable iff (!rst_n)
    cmp_valid |-> $past(dma_done || pio_fire || hold_full));
endmodule

// File: rtl/dma_dispatch.sv
module dma_dispatch #(
  parameter int ADDR_W     = 32,
  parameter int LEN_W      = 16,
  parameter int TAG_W      = 4,
  parameter int DEPTH      = 4,
  parameter int THRESH_RST = 168
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              hi_valid,
  output logic              hi_ready,
  input  logic              hi_dir,
  input  logic [ADDR_W-1:0] hi_laddr,
  input  logic [ADDR_W-1:0] hi_raddr,
  input  logic [LEN_W-1:0]  hi_len,
  input  logic [TAG_W-1:0]  hi_tag,
  input  logic              lo_valid,
  output logic              lo_ready,
  input  logic              lo_dir,
  input  logic [ADDR_W-1:0] lo_laddr,
  input  logic [ADDR_W-1:0] lo_raddr,
  input  logic [LEN_W-1:0]  lo_len,
  input  logic [TAG_W-1:0]  lo_tag,
  input  logic              thr_we,
  input  logic [LEN_W-1:0]  thr_wdata,
  output logic              dma_valid,
  input  logic              dma_ready,
  output logic              dma_dir,
  output logic [ADDR_W-1:0] dma_laddr,
  output logic [ADDR_W-1:0] dma_raddr,
  output logic [LEN_W-1:0]  dma_len,
  output logic [TAG_W-1:0]  dma_tag,
  input  logic              dma_done,
  input  logic [TAG_W-1:0]  dma_done_tag,
  output logic              pio_valid,
  input  logic              pio_ready,
  output logic              pio_dir,
  output logic [ADDR_W-1:0] pio_laddr,
  output logic [ADDR_W-1:0] pio_raddr,
  output logic [LEN_W-1:0]  pio_len,
  output logic [TAG_W-1:0]  pio_tag,
  output logic              cmp_valid,
  output logic [TAG_W-1:0]  cmp_tag,
  output logic              cmp_pio
);
  import dmad_pkg::*;

  localparam int RW = 1 + 2 * ADDR_W + LEN_W + TAG_W;

  logic          q_in_valid [NUM_CLASS];
  logic          q_in_ready [NUM_CLASS];
  logic [RW-1:0] q_in_data  [NUM_CLASS];
  logic          q_avail    [NUM_CLASS];
  logic          q_pop      [NUM_CLASS];
  logic [RW-1:0] q_head     [NUM_CLASS];

  logic [RW-1:0] req_data;
  logic          pio_fire, hold_full;

  assign q_in_valid[CLS_HI] = hi_valid;
  assign q_in_data[CLS_HI]  = {hi_dir, hi_laddr, hi_raddr, hi_len, hi_tag};
  assign q_in_valid[CLS_LO] = lo_valid;
  assign q_in_data[CLS_LO]  = {lo_dir, lo_laddr, lo_raddr, lo_len, lo_tag};
  assign hi_ready = q_in_ready[CLS_HI];
  assign lo_ready = q_in_ready[CLS_LO];

  for (genvar c = 0; c < NUM_CLASS; c++) begin : g_queue
    dmad_fifo #(.W(RW), .DEPTH(DEPTH)) i_fifo (
      .clk      (clk),
      .rst_n    (rst_n),
      .in_valid (q_in_valid[c]),
      .in_ready (q_in_ready[c]),
      .in_data  (q_in_data[c]),
      .out_valid(q_avail[c]),
      .out_pop  (q_pop[c]),
      .out_data (q_head[c])
    );
  end

  dmad_select #(
    .RW(RW), .LEN_W(LEN_W), .TAG_W(TAG_W), .THRESH_RST(THRESH_RST)
  ) i_select (
    .clk      (clk),
    .rst_n    (rst_n),
    .hi_avail (q_avail[CLS_HI]),
    .hi_head  (q_head[CLS_HI]),
    .lo_avail (q_avail[CLS_LO]),
    .lo_head  (q_head[CLS_LO]),
    .thr_we   (thr_we),
    .thr_wdata(thr_wdata),
    .dma_ready(dma_ready),
    .dma_done (dma_done),
    .pio_ready(pio_ready),
    .pio_block(hold_full),
    .hi_pop   (q_pop[CLS_HI]),
    .lo_pop   (q_pop[CLS_LO]),
    .dma_valid(dma_valid),
    .pio_valid(pio_valid),
    .pio_fire (pio_fire),
    .req_data (req_data)
  );

  assign {dma_dir, dma_laddr, dma_raddr, dma_len, dma_tag} = req_data;
  assign {pio_dir, pio_laddr, pio_raddr, pio_len, pio_tag} = req_data;

  dmad_complete #(.TAG_W(TAG_W)) i_complete (
    .clk         (clk),
    .rst_n       (rst_n),
    .dma_done    (dma_done),
    .dma_done_tag(dma_done_tag),
    .pio_fire    (pio_fire),
    .pio_tag     (pio_tag),
    .hold_full   (hold_full),
    .cmp_valid   (cmp_valid),
    .cmp_tag     (cmp_tag),
    .cmp_pio     (cmp_pio)
  );
endmodule

// File: tb/test_dma_dispatch.sv
module test_dma_dispatch;
  localparam int CLK_P = 10;
  localparam int AW = 32, LW = 16, TW = 4;

  logic clk = 1'b0, rst_n = 1'b0;
  logic hi_valid = 0, hi_ready, hi_dir = 0;
  logic [AW-1:0] hi_laddr = '0, hi_raddr = '0;
  logic [LW-1:0] hi_len = '0;
  logic [TW-1:0] hi_tag = '0;
  logic lo_valid = 0, lo_ready, lo_dir = 0;
  logic [AW-1:0] lo_laddr = '0, lo_raddr = '0;
  logic [LW-1:0] lo_len = '0;
  logic [TW-1:0] lo_tag = '0;
  logic thr_we = 0;
  logic [LW-1:0] thr_wdata = '0;
  logic dma_valid, dma_ready = 0, dma_dir;
  logic [AW-1:0] dma_laddr, dma_raddr;
  logic [LW-1:0] dma_len;
  logic [TW-1:0] dma_tag;
  logic dma_done = 0;
  logic [TW-1:0] dma_done_tag = '0;
  logic pio_valid, pio_ready = 0, pio_dir;
  logic [AW-1:0] pio_laddr, pio_raddr;
  logic [LW-1:0] pio_len;
  logic [TW-1:0] pio_tag;
  logic cmp_valid, cmp_pio;
  logic [TW-1:0] cmp_tag;

  int n_chk = 0, n_fail = 0;
  bit finished = 0;

  always #(CLK_P / 2) clk = ~clk;

  dma_dispatch i_dma_dispatch (.*);

  // Vector: {urgent, len[15:0], tag[3:0], dir, expect_pio}; threshold 168
  localparam logic [22:0] VEC [8] = '{
    {1'b1, 16'd40,    4'd1, 1'b0, 1'b1},
    {1'b0, 16'd167,   4'd2, 1'b1, 1'b1},
    {1'b1, 16'd168,   4'd3, 1'b0, 1'b0},
    {1'b0, 16'd1500,  4'd4, 1'b1, 1'b0},
    {1'b1, 16'd0,     4'd5, 1'b0, 1'b1},
    {1'b0, 16'd169,   4'd6, 1'b0, 1'b0},
    {1'b1, 16'd64,    4'd7, 1'b1, 1'b1},
    {1'b0, 16'd65535, 4'd8, 1'b0, 1'b0}
  };

  task automatic check(input string r, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", r, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  function automatic logic [AW-1:0] laddr_of(input logic [LW-1:0] l);
    return 32'h1000_0000 + AW'(l);
  endfunction

  function automatic logic [AW-1:0] raddr_of(input logic [TW-1:0] t);
    return 32'h2000_0000 ^ AW'(t);
  endfunction

  task automatic set_req(input bit urgent, input logic [LW-1:0] l, input logic [TW-1:0] t, input bit d);
    if (urgent) begin
      hi_valid = 1; hi_len = l; hi_tag = t; hi_dir = d;
      hi_laddr = laddr_of(l); hi_raddr = raddr_of(t);
    end else begin
      lo_valid = 1; lo_len = l; lo_tag = t; lo_dir = d;
      lo_laddr = laddr_of(l); lo_raddr = raddr_of(t);
    end
  endtask

  task automatic push(input bit urgent, input logic [LW-1:0] l, input logic [TW-1:0] t, input bit d);
    set_req(urgent, l, t, d);
    tick();
    hi_valid = 0; lo_valid = 0;
  endtask

  task automatic dma_accept();
    dma_ready = 1; tick(); dma_ready = 0;
  endtask

  task automatic dma_finish(input logic [TW-1:0] t);
    dma_done = 1; dma_done_tag = t; tick(); dma_done = 0;
  endtask

  task automatic drain_one_dma(input logic [TW-1:0] t, input string r);
    check(r, dma_valid, 1);
    check(r, dma_tag, t);
    dma_accept();
    dma_finish(t);
  endtask

  initial begin
    #(CLK_P * 100000);
    if (!finished) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);

    // Reset state (R1)
    check("R1 hi_ready", hi_ready, 1);
    check("R1 lo_ready", lo_ready, 1);
    check("R1 dma_valid", dma_valid, 0);
    check("R1 pio_valid", pio_valid, 0);
    check("R1 cmp_valid", cmp_valid, 0);

    // Table walk: routing at the reset threshold (R1, R4, R8)
    for (int i = 0; i < 8; i++) begin
      logic [LW-1:0] l;
      logic [TW-1:0] t;
      bit u, d, ep;
      u = VEC[i][22]; l = VEC[i][21:6]; t = VEC[i][5:2]; d = VEC[i][1]; ep = VEC[i][0];
      push(u, l, t, d);
      check("R1 R4 pio_valid route", pio_valid, ep);
      check("R4 dma_valid route", dma_valid, !ep);
      if (ep) begin
        check("R4 pio fields", {pio_dir, pio_laddr, pio_raddr, pio_len, pio_tag},
              {d, laddr_of(l), raddr_of(t), l, t});
        pio_ready = 1; tick(); pio_ready = 0;
        check("R8 pio completion", {cmp_valid, cmp_pio, cmp_tag}, {1'b1, 1'b1, t});
        tick();
        check("R8 single pulse", cmp_valid, 0);
      end else begin
        check("R4 dma fields", {dma_dir, dma_laddr, dma_raddr, dma_len, dma_tag},
              {d, laddr_of(l), raddr_of(t), l, t});
        dma_accept();
        check("R8 no early completion", cmp_valid, 0);
        dma_finish(t);
        check("R8 dma completion", {cmp_valid, cmp_pio, cmp_tag}, {1'b1, 1'b0, t});
      end
    end

    // Strict priority, single engine, non-blocking dispatch (R3, R5, R6, R8)
    set_req(0, 16'd500, 4'd9, 0);
    set_req(1, 16'd500, 4'd10, 0);
    tick();
    hi_valid = 0; lo_valid = 0;
    check("R3 urgent first", dma_tag, 4'd10);
    check("R3 urgent valid", dma_valid, 1);
    dma_accept();
    check("R5 engine busy blocks bulk", dma_valid, 0);
    push(1, 16'd20, 4'd11, 1);
    check("R6 pio while engine busy", pio_valid, 1);
    check("R6 pio tag", pio_tag, 4'd11);
    pio_ready = 1; tick(); pio_ready = 0;
    check("R8 pio cmp during dma", {cmp_valid, cmp_pio, cmp_tag}, {1'b1, 1'b1, 4'd11});
    check("R5 still busy", dma_valid, 0);
    dma_finish(4'd10);
    check("R8 dma cmp", {cmp_valid, cmp_pio, cmp_tag}, {1'b1, 1'b0, 4'd10});
    check("R3 bulk after idle", {dma_valid, dma_tag}, {1'b1, 4'd9});
    dma_accept();
    dma_finish(4'd9);

    // Simultaneous completions (R8)
    push(1, 16'd300, 4'd3, 0);
    dma_accept();
    push(1, 16'd10, 4'd4, 0);
    check("R6 pio offered", pio_valid, 1);
    pio_ready = 1; dma_done = 1; dma_done_tag = 4'd3;
    tick();
    pio_ready = 0; dma_done = 0;
    check("R8 collision dma first", {cmp_valid, cmp_pio, cmp_tag}, {1'b1, 1'b0, 4'd3});
    tick();
    check("R8 collision pio second", {cmp_valid, cmp_pio, cmp_tag}, {1'b1, 1'b1, 4'd4});

    // Threshold rewrite (R7)
    thr_we = 1; thr_wdata = 16'd64; tick(); thr_we = 0;
    push(1, 16'd100, 4'd5, 0);
    check("R7 len 100 to dma", dma_valid, 1);
    check("R7 len 100 not pio", pio_valid, 0);
    dma_accept();
    dma_finish(4'd5);
    push(0, 16'd63, 4'd6, 0);
    check("R7 len 63 to pio", pio_valid, 1);
    pio_ready = 1; tick(); pio_ready = 0;
    tick();

    // Full queue back-pressure and order (R2, R9)
    for (int k = 1; k <= 4; k++) push(1, 16'd500, 4'(k), 0);
    check("R2 full ready low", hi_ready, 0);
    check("R2 bulk unaffected", lo_ready, 1);
    push(1, 16'd500, 4'd7, 0);
    check("R9 offer held", {dma_valid, dma_tag}, {1'b1, 4'd1});
    for (int k = 1; k <= 4; k++) drain_one_dma(4'(k), "R2 order");
    check("R2 refused push absent dma", dma_valid, 0);
    check("R2 refused push absent pio", pio_valid, 0);
    check("R2 ready back", hi_ready, 1);

    finished = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule